// File: doc/BRIEF.md
# SCSI Command Byte Capture Unit

This unit sits beside the register file of a parallel SCSI initiator. It watches host register writes and records the bytes of a command descriptor block that the host writes to the data output register while the bus is in the command phase. It also decodes the target ID from a one-hot value that the host writes to the data output register during selection. When the host releases the bus, the unit decides whether the recorded command is complete and reports the result.

The surrounding register block supplies the current three-bit bus phase and the current initiator command register value. Each host write arrives as one strobe cycle with a register selector and a data byte. The expected command length comes from the opcode group, which is bits [7:5] of the first captured byte. Executing the command is left to logic downstream, which reads the captured bytes, the byte count and the target ID.

Top module: `scsi_cmd_capture`

## Requirements
- R1: After reset, `cmd_count`, `target_id`, `cmd_done`, `cmd_bad` and every captured byte are zero.
- R2: A data write (`wr_reg` = 2'b00) while `cur_phase` = 3'b010 stores `wr_data` at index `cmd_count` and increments `cmd_count`. Both changes are visible after the next clock edge.
- R3: A data write while `cur_phase` is not 3'b010 leaves `cmd_count` and the captured bytes unchanged.
- R4: A phase write (`wr_reg` = 2'b11) with `wr_data[2:0]` = 3'b010 clears `cmd_count` to zero. A phase write with any other code leaves it unchanged.
- R5: The buffer holds 16 bytes. `cmd_count` saturates at 16, and further data writes in command phase change neither the count nor any stored byte.
- R6: A data write while `cur_icr` = 8'h04 ignores bit 7 of the data. If bits [6:0] hold exactly one set bit at position k, `target_id` becomes k on the next clock edge.
- R7: During selection, a data write whose bits [6:0] are zero or have more than one bit set leaves `target_id` unchanged.
- R8: A release is an initiator command write (`wr_reg` = 2'b01) of 8'h00 while `cur_phase` = 3'b010 and `cmd_count` is non-zero. On a release, the group (byte 0 bits [7:5]) sets the expected length: group 0 expects 6 bytes, groups 1 and 2 expect 10, and group 5 expects 12. `cmd_done` pulses on the next cycle only if `cmd_count` equals the expected length.
- R9: On a release where the group is 3, 4, 6 or 7, `cmd_bad` pulses on the next cycle, whatever the count, and `cmd_done` stays low.
- R10: An initiator command write of a non-zero value, a release attempt outside command phase, and a release with `cmd_count` = 0 produce neither pulse.
- R11: `cmd_done` and `cmd_bad` are never high together, and each lasts one cycle after a single release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| wr_reg | input | 2 | Register selector: 00 data out, 01 initiator command, 11 phase |
| wr_data | input | 8 | Host write data |
| cur_phase | input | 3 | Current bus phase code (3'b010 = command) |
| cur_icr | input | 8 | Current initiator command register value |
| cmd_bytes | output | 128 | Captured bytes, byte k at bits [8k+7:8k] |
| cmd_count | output | 5 | Number of captured bytes |
| target_id | output | 3 | Decoded target ID |
| cmd_done | output | 1 | Command-complete pulse |
| cmd_bad | output | 1 | Unknown opcode group pulse |

## Verification
The bench builds the unit with its default 16-byte buffer and 8-bit data. At that size it can sweep every one of the eight opcode groups against every byte count from 0 to 17. This covers each exact length match, each near miss and the saturation past 16 in a single nested loop. All 128 values of the low seven data bits are swept during selection, with bit 7 alternating, which covers every one-hot and every rejected pattern.

// File: rtl/scsi_cap_pkg.sv
package scsi_cap_pkg;
  localparam logic [1:0] SEL_DATA  = 2'b00;
  localparam logic [1:0] SEL_ICR   = 2'b01;
  localparam logic [1:0] SEL_PHASE = 2'b11;

  localparam logic [2:0] PHASE_CMD   = 3'b010;
  localparam logic [7:0] ICR_SELECT  = 8'h04;
  localparam logic [7:0] ICR_RELEASE = 8'h00;

  typedef struct packed {
    logic       known;
    logic [3:0] len;
  } grp_len_t;
endpackage

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
  import scsi_cap_pkg::*;
(
  input  logic [2:0] group,
  output grp_len_t   info
);
  always_comb begin
    info.known = 1'b1;
    info.len   = 4'd0;
    case (group)
      3'd0:       info.len = 4'd6;
      3'd1, 3'd2: info.len = 4'd10;
      3'd5:       info.len = 4'd12;
      default:    info.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sel_id_decode.sv
module sel_id_decode #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [DATA_W-1:0] data,
  output logic [ID_W-1:0]   id,
  output logic              hit
);
  localparam int LINES = DATA_W - 1;

  logic [LINES-1:0] low;
  assign low = data[LINES-1:0];

  always_comb begin
    hit = 1'b0;
    id  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (low == LINES'(1) << i) begin
        hit = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/cmd_byte_buffer.sv
module cmd_byte_buffer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DEPTH*DATA_W-1:0] rdata
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign rdata[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/scsi_cmd_capture.sv
module scsi_cmd_capture
  import scsi_cap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [1:0]              wr_reg,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [2:0]              cur_phase,
  input  logic [DATA_W-1:0]       cur_icr,
  output logic [DEPTH*DATA_W-1:0] cmd_bytes,
  output logic [CNT_W-1:0]        cmd_count,
  output logic [ID_W-1:0]         target_id,
  output logic                    cmd_done,
  output logic                    cmd_bad
);
  logic            in_cmd, wr_data_sel, wr_icr_sel, wr_phase_sel;
  logic            store_en, enter_cmd, release_ev;
  logic            sel_hit;
  logic [ID_W-1:0] sel_id;
  grp_len_t        grp;

  logic [CNT_W-1:0] count_q, count_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             done_q, done_d, bad_q, bad_d;

  assign in_cmd       = (cur_phase == PHASE_CMD);
  assign wr_data_sel  = wr_stb && (wr_reg == SEL_DATA);
  assign wr_icr_sel   = wr_stb && (wr_reg == SEL_ICR);
  assign wr_phase_sel = wr_stb && (wr_reg == SEL_PHASE);

  assign store_en   = wr_data_sel && in_cmd && (count_q < CNT_W'(DEPTH));
  assign enter_cmd  = wr_phase_sel && (wr_data[2:0] == PHASE_CMD);
  assign release_ev = wr_icr_sel && (wr_data == ICR_RELEASE) && in_cmd
                      && (count_q != '0);

  cmd_byte_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(CNT_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_en),
    .waddr (count_q),
    .wdata (wr_data),
    .rdata (cmd_bytes)
  );

  cmd_len_decode u_len (
    .group (cmd_bytes[DATA_W-1 -: 3]),
    .info  (grp)
  );

  sel_id_decode #(.DATA_W(DATA_W), .ID_W(ID_W)) u_sel (
    .data (wr_data),
    .id   (sel_id),
    .hit  (sel_hit)
  );

  always_comb begin
    count_d = count_q;
    id_d    = id_q;
    done_d  = 1'b0;
    bad_d   = 1'b0;
    if (enter_cmd)     count_d = '0;
    else if (store_en) count_d = count_q + 1'b1;
    if (wr_data_sel && (cur_icr == ICR_SELECT) && sel_hit) id_d = sel_id;
    if (release_ev) begin
      if (!grp.known) bad_d = 1'b1;
      else if (count_q == CNT_W'(grp.len)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      id_q    <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      id_q    <= id_d;
      done_q  <= done_d;
      bad_q   <= bad_d;
    end
  end

  assign cmd_count = count_q;
  assign target_id = id_q;
  assign cmd_done  = done_q;
  assign cmd_bad   = bad_q;
endmodule

// File: rtl/scsi_cmd_capture_chk.sv
module scsi_cmd_capture_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [1:0]        wr_reg,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        cur_phase,
  input logic [DATA_W-1:0] cur_icr,
  input logic [CNT_W-1:0]  cmd_count,
  input logic [ID_W-1:0]   target_id,
  input logic              cmd_done,
  input logic              cmd_bad
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_count <= CNT_W'(DEPTH)); // R5

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_bad)); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd_count != $past(cmd_count)) |->
      (cmd_count == '0 || cmd_count == $past(cmd_count) + 1'b1)); // R2

  AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_reg == 2'b00 && cur_phase != 3'b010) |=> $stable(cmd_count)); // R3

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_reg == 2'b00 && cur_icr == 8'h04) |=> $stable(target_id)); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd_done) |->
      $past(wr_stb && wr_reg == 2'b01 && wr_data == 8'h00 && cur_phase == 3'b010)); // R8

  AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd_bad) |->
      $past(wr_stb && wr_reg == 2'b01 && wr_data == 8'h00 && cur_phase == 3'b010)); // R9
endmodule

bind scsi_cmd_capture scsi_cmd_capture_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_reg(wr_reg),
  .wr_data(wr_data), .cur_phase(cur_phase), .cur_icr(cur_icr),
  .cmd_count(cmd_count), .target_id(target_id),
  .cmd_done(cmd_done), .cmd_bad(cmd_bad)
);

// File: tb/scsi_cmd_capture_test.sv
`timescale 1ns/1ps
module scsi_cmd_capture_test;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_stb = 1'b0;
  logic [1:0]   wr_reg = 2'b00;
  logic [7:0]   wr_data = 8'h00;
  logic [2:0]   cur_phase = 3'b000;
  logic [7:0]   cur_icr = 8'h00;
  logic [127:0] cmd_bytes;
  logic [4:0]   cmd_count;
  logic [2:0]   target_id;
  logic         cmd_done, cmd_bad;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scsi_cmd_capture uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_reg(wr_reg),
    .wr_data(wr_data), .cur_phase(cur_phase), .cur_icr(cur_icr),
    .cmd_bytes(cmd_bytes), .cmd_count(cmd_count), .target_id(target_id),
    .cmd_done(cmd_done), .cmd_bad(cmd_bad)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] r, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  function automatic int exp_len(input int g);
    if (g == 0) return 6;
    if (g == 1 || g == 2) return 10;
    if (g == 5) return 12;
    return -1;
  endfunction

  function automatic logic [7:0] pat(input int g, input int n, input int k);
    if (k == 0) return 8'((g << 5) | (n & 31));
    return 8'(k * 37 + n * 3 + g);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", cmd_count, 0);
    check("R1 id", target_id, 0);
    check("R1 done", cmd_done, 0);
    check("R1 bad", cmd_bad, 0);
    check("R1 bytes", int'(cmd_bytes != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: data writes outside command phase
    cur_phase = 3'b000; cur_icr = 8'h01;
    host_wr(2'b00, 8'hAA);
    host_wr(2'b00, 8'h55);
    check("R3 count", cmd_count, 0);
    check("R3 byte0", cmd_bytes[7:0], 0);

    // R2, R4: capture then phase writes
    cur_phase = 3'b010;
    host_wr(2'b11, 8'h02);
    host_wr(2'b00, 8'h3C);
    check("R2 count", cmd_count, 1);
    check("R2 byte0", cmd_bytes[7:0], 8'h3C);
    host_wr(2'b11, 8'h01);
    check("R4 other phase keeps", cmd_count, 1);
    host_wr(2'b11, 8'hFA);
    check("R4 enter clears", cmd_count, 0);

    // R10: non-zero ICR write and release with zero count
    host_wr(2'b01, 8'h00);
    check("R10 zero count done", cmd_done, 0);
    check("R10 zero count bad", cmd_bad, 0);

    // R8 R9 R5 R11 sweep: every group, counts 0..17
    for (int g = 0; g < 8; g++) begin
      for (int n = 0; n <= DEPTH + 1; n++) begin
        int  len;
        bit  ok;
        cur_phase = 3'b010; cur_icr = 8'h01;
        host_wr(2'b11, 8'h02);
        for (int k = 0; k < n; k++) host_wr(2'b00, pat(g, n, k));
        check("R5 count", cmd_count, (n > DEPTH) ? DEPTH : n);
        ok = 1'b1;
        for (int k = 0; k < DEPTH && k < n; k++)
          if (cmd_bytes[k*8 +: 8] != pat(g, n, k)) ok = 1'b0;
        check("R2 bytes", int'(ok), 1);
        host_wr(2'b01, 8'h01);
        check("R10 nonzero icr", int'(cmd_done | cmd_bad), 0);
        len = exp_len(g);
        host_wr(2'b01, 8'h00);
        if (len < 0) begin
          check("R9 bad", cmd_bad, (n > 0) ? 1 : 0);
          check("R9 done", cmd_done, 0);
        end else begin
          check("R8 done", cmd_done, (n == len) ? 1 : 0);
          check("R8 bad", cmd_bad, 0);
        end
        @(negedge clk);
        check("R11 pulse width", int'(cmd_done | cmd_bad), 0);
      end
    end

    // R10: release outside command phase after a complete group-0 command
    cur_phase = 3'b010;
    host_wr(2'b11, 8'h02);
    for (int k = 0; k < 6; k++) host_wr(2'b00, pat(0, 6, k));
    cur_phase = 3'b011;
    host_wr(2'b01, 8'h00);
    check("R10 outside phase", int'(cmd_done | cmd_bad), 0);

    // R6 R7 selection sweep
    cur_phase = 3'b000; cur_icr = 8'h04;
    begin
      int expid;
      expid = 0;
      for (int v = 0; v < 128; v++) begin
        logic [7:0] d;
        d = 8'(v) | ((v % 2) ? 8'h80 : 8'h00);
        host_wr(2'b00, d);
        if ($countones(v) == 1) begin
          expid = $clog2(v);
          check("R6 id", target_id, expid);
        end else begin
          check("R7 id held", target_id, expid);
        end
      end
      cur_icr = 8'h05;
      host_wr(2'b00, 8'h10);
      check("R6 not selecting", target_id, expid);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule